// File: doc/BRIEF.md
# Quasi-Resonant Valley Switching Sequencer

This block decides when the power switch of a quasi-resonant flyback converter turns on and off. While the switch is off, it watches a synchronized comparator flag that goes high when the demagnetization sense level drops below its low threshold. It counts each new drop as one zero crossing and turns the switch on at the valley picked by an external selector. A ringing-suppression interval follows each turn-off, and no turn-on is allowed inside it. Its length depends on whether the sense level was high or low when the gate fell.

While the switch is on, the block ends the pulse on either of two current comparators: the current-mode comparator or the peak-limit comparator. Both are ignored for a short leading-edge blanking window. A maximum on-time forces turn-off. A maximum switching period, counted from the last turn-on, forces the next turn-on when the ringing dies out before enough crossings are seen. A supervisor enable holds the gate low and clears the sequencer. All times come from a clock-frequency parameter as cycle counts: 280 ns blanking, 2.8 µs and 25 µs suppression, 30 µs maximum on-time and 50 µs maximum period.

Top module: `qr_valley_seq`

## Requirements
- R1: After reset, `gate` is 0 while `en` is 0. The first clock edge that samples `en` high sets `gate` to 1, with no wait for suppression or crossings.
- R2: While `en` is 0, `gate` is 0 in the same cycle, combinationally. Every timer, the crossing count and the suppression state are cleared, so the next turn-on follows R1.
- R3: A zero crossing is a 0-to-1 change of `zc_low` (1 = sense below the low threshold) between two edges at which the gate is off. Changes during on-time are not counted.
- R4: The crossing count saturates at 7 and returns to 0 on every turn-on.
- R5: At turn-off, `zc_high` (1 = sense above the high threshold) picks the suppression length: SUP_SHORT cycles (2.8 µs) when 1, SUP_LONG cycles (25 µs) when 0. The value sampled on the turn-off edge is used, not later values. The gate stays low for at least that many cycles unless R8 forces a turn-on.
- R6: After suppression, the gate rises on the edge after the one at which the count is at least `valley_sel`. A `zc_low` rise sampled at edge E raises the gate at edge E+1. With `valley_sel` = 0, the gate rises right after suppression.
- R7: `trip_pwm` and `trip_peak` are ignored during the first LEB cycles of on-time (280 ns). A trip present in on-time cycle k (0-based) gives an on-time of max(k, LEB)+1 cycles.
- R8: The gate rises TPER cycles (50 µs) after its previous rise if it has not risen earlier. This forced turn-on ignores the crossing count and any suppression still running.
- R9: The gate is never high for more than TON consecutive cycles (30 µs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Supervisor enable; low holds the gate off and clears state |
| zc_low | input | 1 | Sense level below the zero-crossing threshold (synchronized) |
| zc_high | input | 1 | Sense level above the suppression-select threshold (synchronized) |
| trip_pwm | input | 1 | Current-mode comparator: scaled current above feedback level |
| trip_peak | input | 1 | Peak current limit comparator |
| valley_sel | input | 3 | Number of crossings required before turn-on |
| gate | output | 1 | Power switch gate command |

## Verification
The crossing count, the suppression counter and the shared since-turn-on timer are internal, but a wrong value in any of them moves a gate edge. The error shows in the next off-time length or on-time length. It appears within one switching period, and never more than TPER cycles later. Each valley setting therefore maps to an exact off-time in cycles. The count is clear-on-turn-on, so a missing clear makes the following period turn on early. A counter that wraps instead of saturating falls back to the forced-period length. A suppression length latched from the wrong cycle of `zc_high` swaps a short wait for a long one.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

  // Reason the sequencer starts a new on-time.
  typedef enum logic [1:0] {
    ON_NONE   = 2'd0,
    ON_FIRST  = 2'd1,
    ON_VALLEY = 2'd2,
    ON_PERIOD = 2'd3
  } on_cause_e;

  // Convert a duration in ns to whole clock cycles, rounding up.
  function automatic int ns_to_cyc(input int ns, input int clk_mhz);
    return (ns * clk_mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/qrv_valley_counter.sv
module qrv_valley_counter #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          gate_q,
  input  logic          turn_on,
  input  logic          zc_low,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          zc_d_q, zc_d_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          crossing;

  // Falling sense edge seen only while the switch is off.
  assign crossing = zc_low & ~zc_d_q & ~gate_q;

  always_comb begin
    zc_d_d = zc_low;
    cnt_d  = cnt_q;
    if (!en || turn_on) begin
      cnt_d = '0;
    end else if (crossing && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_d_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      zc_d_q <= zc_d_d;
      cnt_q  <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/qrv_suppress.sv
module qrv_suppress #(
  parameter int SUP_SHORT = 28,
  parameter int SUP_LONG  = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic turn_off,
  input  logic turn_on,
  input  logic level_hi,
  output logic busy
);

  localparam int SW = $clog2(SUP_LONG + 1);
  localparam logic [SW-1:0] LOAD_SHORT = SW'(SUP_SHORT - 1);
  localparam logic [SW-1:0] LOAD_LONG  = SW'(SUP_LONG - 1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = 1'b1;
    cnt_d  = cnt_q;
    if (!en || turn_on) begin
      cnt_d = '0;
    end else if (turn_off) begin
      // Length fixed by the level present on the falling edge of the gate.
      cnt_d = level_hi ? LOAD_SHORT : LOAD_LONG;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_ce = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/qrv_period_timer.sv
module qrv_period_timer #(
  parameter int LEB_CYC = 3,
  parameter int TON_CYC = 300,
  parameter int TPER_CYC = 500,
  parameter int NTRIP   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gate_q,
  input  logic             turn_on,
  input  logic [NTRIP-1:0] trip,
  output logic             off_req,
  output logic             per_hit
);

  localparam int PW = $clog2(TPER_CYC + 1);
  localparam logic [PW-1:0] LEB_V  = PW'(LEB_CYC);
  localparam logic [PW-1:0] TON_V  = PW'(TON_CYC - 1);
  localparam logic [PW-1:0] TPER_V = PW'(TPER_CYC - 1);

  logic [PW-1:0]    cnt_q, cnt_d;
  logic             cnt_ce;
  logic             blank;
  logic [NTRIP-1:0] trip_ok;

  // One counter since the last turn-on serves blanking, on-time and period.
  always_comb begin
    cnt_ce = 1'b1;
    cnt_d  = cnt_q;
    if (!en || turn_on) begin
      cnt_d = '0;
    end else if (cnt_q != TPER_V) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_ce = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign blank = (cnt_q < LEB_V);

  generate
    for (genvar i = 0; i < NTRIP; i++) begin : g_trip
      assign trip_ok[i] = trip[i] & ~blank;
    end
  endgenerate

  assign off_req = gate_q & ((|trip_ok) | (cnt_q == TON_V));
  assign per_hit = (cnt_q == TPER_V);

endmodule

// File: rtl/qr_valley_seq.sv
module qr_valley_seq #(
  parameter int CLK_MHZ = 200,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          zc_low,
  input  logic          zc_high,
  input  logic          trip_pwm,
  input  logic          trip_peak,
  input  logic [CW-1:0] valley_sel,
  output logic          gate
);

  import qrv_pkg::*;

  localparam int LEB_CYC   = ns_to_cyc(280, CLK_MHZ);
  localparam int SUP_SHORT = ns_to_cyc(2800, CLK_MHZ);
  localparam int SUP_LONG  = ns_to_cyc(25000, CLK_MHZ);
  localparam int TON_CYC   = ns_to_cyc(30000, CLK_MHZ);
  localparam int TPER_CYC  = ns_to_cyc(50000, CLK_MHZ);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];

  logic          gate_q, gate_d;
  logic          first_q, first_d;
  logic          turn_on, turn_off;
  logic          off_req, per_hit, sup_busy;
  logic [CW-1:0] zc_cnt;
  on_cause_e     cause;

  qrv_valley_counter #(.CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .en      (en),
    .gate_q  (gate_q),
    .turn_on (turn_on),
    .zc_low  (zc_low),
    .count   (zc_cnt)
  );

  qrv_suppress #(.SUP_SHORT(SUP_SHORT), .SUP_LONG(SUP_LONG)) u_sup (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .en       (en),
    .turn_off (turn_off),
    .turn_on  (turn_on),
    .level_hi (zc_high),
    .busy     (sup_busy)
  );

  qrv_period_timer #(
    .LEB_CYC (LEB_CYC),
    .TON_CYC (TON_CYC),
    .TPER_CYC(TPER_CYC),
    .NTRIP   (2)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .en      (en),
    .gate_q  (gate_q),
    .turn_on (turn_on),
    .trip    ({trip_peak, trip_pwm}),
    .off_req (off_req),
    .per_hit (per_hit)
  );

  // Turn-on arbitration: first pulse, then period watchdog, then valley.
  always_comb begin
    cause = ON_NONE;
    if (en && !gate_q) begin
      if (first_q) begin
        cause = ON_FIRST;
      end else if (per_hit) begin
        cause = ON_PERIOD;
      end else if (!sup_busy && (zc_cnt >= valley_sel)) begin
        cause = ON_VALLEY;
      end
    end
  end

  assign turn_on  = (cause != ON_NONE);
  assign turn_off = en & off_req;

  always_comb begin
    gate_d  = gate_q;
    first_d = first_q;
    if (!en) begin
      gate_d  = 1'b0;
      first_d = 1'b1;
    end else if (turn_on) begin
      gate_d  = 1'b1;
      first_d = 1'b0;
    end else if (turn_off) begin
      gate_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      gate_q  <= 1'b0;
      first_q <= 1'b1;
    end else begin
      gate_q  <= gate_d;
      first_q <= first_d;
    end
  end

  assign gate = gate_q & en;

endmodule

// File: rtl/qrv_checker.sv
module qrv_checker #(
  parameter int LEB_CYC = 3,
  parameter int TON_CYC = 300,
  parameter int CW      = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          gate,
  input logic          gate_q,
  input logic [CW-1:0] zc_cnt,
  input logic          sup_busy,
  input logic          per_hit
);

  localparam int HW = $clog2(TON_CYC + 2) + 1;

  logic [HW-1:0] hi_cnt;

  // Consecutive high cycles of the gate output seen so far.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (gate) begin
      if (hi_cnt != {HW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
    end
  end

  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate_q);

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_cnt != $past(zc_cnt)) |-> ((zc_cnt == $past(zc_cnt) + 1'b1) || (zc_cnt == '0)));

  p_count_frozen_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && $past(gate_q)) |-> $stable(zc_cnt));

  p_count_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> (zc_cnt == '0));

  p_suppress_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_q) && $past(sup_busy)) |-> $past(per_hit));

  p_blanking_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate) && en) |-> (hi_cnt >= HW'(LEB_CYC + 1)));

  p_max_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (hi_cnt < HW'(TON_CYC)));

endmodule

bind qr_valley_seq qrv_checker #(
  .LEB_CYC(LEB_CYC),
  .TON_CYC(TON_CYC),
  .CW     (CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .gate     (gate),
  .gate_q   (gate_q),
  .zc_cnt   (zc_cnt),
  .sup_busy (sup_busy),
  .per_hit  (per_hit)
);

// File: tb/qr_valley_seq_test.sv
module qr_valley_seq_test;

  // Small configuration: 10 cycles per microsecond.
  localparam int MHZ   = 10;
  localparam int LEB   = 3;
  localparam int SHORT = 28;
  localparam int LONG  = 250;
  localparam int TON   = 300;
  localparam int TPER  = 500;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic       zc_low;
  logic       zc_high;
  logic       trip_pwm;
  logic       trip_peak;
  logic [2:0] valley_sel;
  logic       gate;

  int total;
  int failed;

  qr_valley_seq #(.CLK_MHZ(MHZ), .CW(3)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .zc_low    (zc_low),
    .zc_high   (zc_high),
    .trip_pwm  (trip_pwm),
    .trip_peak (trip_peak),
    .valley_sel(valley_sel),
    .gate      (gate)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Entered at a negedge where gate is high; returns at the first low sample.
  task automatic run_on(input int k, input bit use_peak, input bit zh,
                        input bit pulse_zc, output int len);
    zc_high = zh;
    len = 0;
    while (gate === 1'b1) begin
      if (len == k) begin
        if (use_peak) trip_peak = 1'b1;
        else          trip_pwm  = 1'b1;
      end
      if (pulse_zc) zc_low = (len >= 2 && len < 5);
      len++;
      @(negedge clk);
    end
    trip_pwm  = 1'b0;
    trip_peak = 1'b0;
    zc_low    = 1'b0;
    zc_high   = ~zh;
  endtask

  // Entered at the first low sample; returns at the first high sample.
  task automatic run_off(input int start, input int spacing, input int ncross,
                         output int len);
    len = 0;
    while (gate === 1'b0) begin
      zc_low = (ncross > 0) && (len >= start) &&
               (((len - start) % spacing) < 3) &&
               (((len - start) / spacing) < ncross);
      len++;
      @(negedge clk);
    end
    zc_low = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++;
    total++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    int on_len;
    int off_len;
    total = 0;
    failed = 0;
    rst_n = 1'b0; en = 1'b0; zc_low = 1'b0; zc_high = 1'b1;
    trip_pwm = 1'b0; trip_peak = 1'b0; valley_sel = 3'd0;
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", gate, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 gate low with en low", gate, 0);

    // R1: first turn-on right after enable.
    en = 1'b1;
    #1;
    chk("R1 no rise before edge", gate, 0);
    @(negedge clk);
    chk("R1 first turn-on", gate, 1);

    // R7 blanking sweep for both comparators, R5 short suppression, valley 0.
    for (int which = 0; which < 2; which++) begin
      for (int k = 0; k < 7; k++) begin
        run_on(k, which[0], 1'b1, 1'b0, on_len);
        chk(which == 0 ? "R7 pwm trip on-time" : "R7 peak trip on-time",
            on_len, ((k > LEB) ? k : LEB) + 1);
        run_off(0, 1, 0, off_len);
        chk("R5 short suppression, R6 valley 0", off_len, SHORT);
      end
    end

    // R5: low level at the falling edge selects the long wait.
    run_on(LEB, 1'b0, 1'b0, 1'b0, on_len);
    chk("R7 on-time", on_len, LEB + 1);
    run_off(0, 1, 0, off_len);
    chk("R5 long suppression", off_len, LONG);

    // R6 valley sweep; last setting repeated to expose a missing clear (R4).
    for (int v = 1; v <= 8; v++) begin
      int vv;
      int expect_off;
      vv = (v > 7) ? 7 : v;
      valley_sel = 3'(vv);
      run_on(LEB, 1'b0, 1'b1, 1'b0, on_len);
      run_off(2, 10, vv + 2, off_len);
      expect_off = 2 + 10 * (vv - 1) + 2;
      if (expect_off < SHORT) expect_off = SHORT;
      chk(v > 7 ? "R4 count cleared at turn-on" : "R6 valley turn-on",
          off_len, expect_off);
    end

    // R3: crossings during on-time are not counted.
    valley_sel = 3'd1;
    run_on(20, 1'b0, 1'b1, 1'b1, on_len);
    chk("R7 late trip on-time", on_len, 21);
    run_off(40, 10, 1, off_len);
    chk("R3 on-time crossing ignored", off_len, 42);

    // R4: nine crossings saturate at 7 instead of wrapping.
    valley_sel = 3'd7;
    run_on(LEB, 1'b0, 1'b0, 1'b0, on_len);
    run_off(2, 10, 9, off_len);
    chk("R4 count saturates", off_len, LONG);

    // R9 max on-time, then R8 forcing through a running suppression.
    run_on(100000, 1'b0, 1'b0, 1'b0, on_len);
    chk("R9 max on-time", on_len, TON);
    run_off(0, 1, 0, off_len);
    chk("R8 forced over suppression", off_len, TPER - TON);

    // R8 max period with too few crossings.
    run_on(LEB, 1'b1, 1'b1, 1'b0, on_len);
    run_off(2, 10, 3, off_len);
    chk("R8 max period", off_len, TPER - (LEB + 1));

    // R2: enable drop mid on-time.
    repeat (5) @(negedge clk);
    chk("R2 gate still on", gate, 1);
    en = 1'b0;
    #1;
    chk("R2 immediate gate off", gate, 0);
    for (int i = 0; i < 20; i++) begin
      zc_low = (i % 4) < 2;
      @(negedge clk);
      if (gate !== 1'b0) chk("R2 gate held low", gate, 0);
    end
    zc_low = 1'b0;
    chk("R2 gate held low", gate, 0);
    valley_sel = 3'd1;
    en = 1'b1;
    @(negedge clk);
    chk("R1 R2 immediate turn-on after enable", gate, 1);
    run_on(LEB, 1'b0, 1'b1, 1'b0, on_len);
    chk("R2 timers cleared, on-time", on_len, LEB + 1);
    run_off(40, 10, 1, off_len);
    chk("R2 counters cleared, valley", off_len, 42);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule